// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes an incoming network frame as a byte stream and lays it down in local memory. The memory is organised as a circular queue of 256-byte pages. The ring spans from a first page up to, but not including, a stop page. A guard page marks the oldest page that software has not yet released. Each stored frame is preceded by a 4-byte descriptor holding a status byte, the page where the next frame will begin and the stored length. The block drops multicast traffic, and it drops broadcast traffic unless broadcast reception is enabled. It pads runt frames with zeros and reports completion and ring overflow through a small write-one-to-clear interrupt status register with a mask.

The payload is written first. The descriptor is written only after the last payload byte has landed, so a reader that follows the page chain never meets a half-written frame. The current-page pointer moves forward only when that descriptor write completes. An overflow leaves the pointer where it was, and it leaves the descriptor unwritten.

The controller is a five-state machine:
- `RX_IDLE` waits for the first byte. It latches the start page and then goes to `RX_TAKE`. If the device is held in reset it goes to `RX_SKIP` instead.
- `RX_TAKE` stores one byte per cycle. It goes to `RX_SKIP` on a filter reject or on an overflow, and goes to `RX_IDLE` instead if that byte was the last one. When a good frame ends it goes to `RX_FILL` if the frame is short, and to `RX_HEAD` otherwise.
- `RX_SKIP` drains the rest of a rejected frame and then returns to `RX_IDLE`.
- `RX_FILL` writes zero bytes until the frame is 60 bytes long, then goes to `RX_HEAD`.
- `RX_HEAD` writes the four descriptor bytes, commits the pointer and the status, and returns to `RX_IDLE`.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame starts at page `cur_page`, or at `ring_first` when `cur_page` equals `ring_last`. Payload byte i goes to byte offset 4+i of the frame, continuing across pages.
- R2: A frame whose first byte has bit 0 set is a broadcast only if its first 6 bytes are all 0xFF. It is kept only when `accept_bcast` is 1. Every other such frame is dropped, and so is a broadcast while `accept_bcast` is 0. A dropped frame writes no descriptor and leaves `cur_page`, `rx_status`, `int_status` and `missed_count` unchanged. Only its first 6 bytes (or fewer, for a shorter frame) may reach their payload offsets.
- R3: On completion `rx_status` becomes 0x21 for a kept broadcast and 0x01 for any other completed frame.
- R4: When the write offset passes the end of a page, the next page is the current page plus 1. If that equals `ring_last`, `ring_first` is used instead. Every memory write falls inside pages ring_first to ring_last-1.
- R5: If the page entered at a crossing equals `guard_page`, the frame is abandoned. `rx_status` becomes 0x10, `int_status` bit 4 is set and `missed_count` increases by 1. No descriptor is written, `cur_page` stays unchanged and the rest of the frame is consumed.
- R6: A frame shorter than 60 bytes is followed by zero bytes up to 60 bytes. Its descriptor length is then 64.
- R7: On completion `cur_page` becomes the page holding the byte after the end, rounded up to the next page boundary, with a value equal to `ring_last` replaced by `ring_first`.
- R8: The descriptor occupies offsets 0..3 of the start page: status byte, next page, then the low and high bytes of (stored length + 4). These are the last four writes of the frame.
- R9: A frame that begins while `dev_reset` is 1 is consumed with no memory write and no change of any output register.
- R10: `int_status` bit 0 is set on completion and bit 4 on overflow. A pulse on `int_clr` clears the bits set in `int_clr_bits`, and a set event in the same cycle wins. `irq` is 1 when any bit of `int_status` AND `int_mask` is 1.
- R11: `cur_load` loads `cur_load_page` into `cur_page`. All output registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| dev_reset | input | 1 | device held in reset; frames are ignored |
| ring_first | input | PAGE_W | first page of the ring |
| ring_last | input | PAGE_W | stop page (one past the last ring page) |
| guard_page | input | PAGE_W | oldest page not yet freed by software |
| accept_bcast | input | 1 | keep broadcast frames |
| cur_load | input | 1 | load strobe for the current page |
| cur_load_page | input | PAGE_W | value to load into the current page |
| in_valid | input | 1 | stream byte valid |
| in_data | input | 8 | stream byte |
| in_last | input | 1 | last byte of the frame |
| in_ready | output | 1 | stream byte accepted this cycle |
| mem_we | output | 1 | memory write enable |
| mem_addr | output | PAGE_W+8 | memory byte address |
| mem_wdata | output | 8 | memory write data |
| int_mask | input | 8 | interrupt mask |
| int_clr | input | 1 | interrupt clear strobe |
| int_clr_bits | input | 8 | status bits to clear |
| int_status | output | 8 | interrupt status |
| irq | output | 1 | interrupt request |
| cur_page | output | PAGE_W | current page pointer |
| rx_status | output | 8 | status of the last finished frame |
| missed_count | output | 8 | frames lost to overflow |

## Verification
The bench builds the block with PAGE_W = 4, so memory is 16 pages (4 KiB) and the ring covers pages 2 to 11. At that size, frames under 700 bytes reach the stop-page wrap, exact page-end rounding and guard-page overflow, and a complete copy of memory can be compared after every frame. All other parameters keep their default values, so the 60-byte minimum and the 6-byte broadcast window are the real ones.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_TAKE,
        RX_SKIP,
        RX_FILL,
        RX_HEAD
    } rxr_state_e;

    // Descriptor is four bytes; its byte order is decoded by software.
    localparam int unsigned RXR_HDR_LEN  = 4;

    localparam int unsigned ISR_DONE_BIT = 0;
    localparam int unsigned ISR_OVF_BIT  = 4;

    localparam logic [7:0] STAT_OK    = 8'h01;
    localparam logic [7:0] STAT_BCAST = 8'h20;
    localparam logic [7:0] STAT_OVF   = 8'h10;

endpackage

// File: rtl/rxr_kind_filter.sv
module rxr_kind_filter #(
    parameter int unsigned BC_LEN = 6,
    localparam int unsigned IDX_W = $clog2(BC_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic [7:0] byte_in,
    input  logic       last_in,
    input  logic       accept_bcast,
    output logic       decide,
    output logic       keep,
    output logic       bcast
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BC_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(BC_LEN);

    logic [IDX_W-1:0] idx_q;
    logic             mc_q;
    logic             ones_q;
    logic             first_b;
    logic             mc_eff;
    logic             ones_eff;
    logic             window_end;

    always_comb begin
        first_b    = (idx_q == '0);
        mc_eff     = first_b ? byte_in[0] : mc_q;
        ones_eff   = (first_b ? 1'b1 : ones_q) && (byte_in == 8'hFF);
        window_end = (idx_q == IDX_LAST);
        decide     = take && (idx_q < IDX_END) && (window_end || last_in);
        bcast      = mc_eff && ones_eff && window_end;
        keep       = !mc_eff || (bcast && accept_bcast);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mc_q   <= 1'b0;
            ones_q <= 1'b1;
        end else if (clear) begin
            idx_q  <= '0;
            mc_q   <= 1'b0;
            ones_q <= 1'b1;
        end else if (take && (idx_q < IDX_END)) begin
            idx_q  <= idx_q + 1'b1;
            mc_q   <= mc_eff;
            ones_q <= ones_eff;
        end
    end

endmodule

// File: rtl/rxr_ptr_unit.sv
module rxr_ptr_unit #(
    parameter int unsigned PAGE_W  = 8,
    parameter int unsigned OFS_W   = 8,
    parameter int unsigned SKIP_AT = 4,
    localparam int unsigned ADDR_W = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              step,
    input  logic [PAGE_W-1:0] ring_first,
    input  logic [PAGE_W-1:0] ring_last,
    input  logic [PAGE_W-1:0] guard_page,
    output logic [ADDR_W-1:0] addr,
    output logic              guard_hit,
    output logic [PAGE_W-1:0] next_page
);
    localparam logic [OFS_W-1:0] OFS_START = OFS_W'(SKIP_AT);

    logic [PAGE_W-1:0] pg_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              at_end;
    logic [PAGE_W-1:0] pg_inc;
    logic [PAGE_W-1:0] pg_adv;
    logic [PAGE_W-1:0] pg_round;

    always_comb begin
        at_end    = &ofs_q;
        pg_inc    = pg_q + 1'b1;
        pg_adv    = (pg_inc == ring_last) ? ring_first : pg_inc;
        guard_hit = step && at_end && (pg_adv == guard_page);
        pg_round  = (ofs_q != '0) ? pg_inc : pg_q;
        next_page = (pg_round == ring_last) ? ring_first : pg_round;
        addr      = {pg_q, ofs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q  <= '0;
            ofs_q <= '0;
        end else if (load) begin
            pg_q  <= load_page;
            ofs_q <= OFS_START;
        end else if (step) begin
            ofs_q <= ofs_q + 1'b1;
            if (at_end) begin
                pg_q <= pg_adv;
            end
        end
    end

endmodule

// File: rtl/rxr_int_unit.sv
module rxr_int_unit #(
    parameter int unsigned ISR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ISR_W-1:0] set_bits,
    input  logic             clr,
    input  logic [ISR_W-1:0] clr_bits,
    input  logic [ISR_W-1:0] mask,
    output logic [ISR_W-1:0] status,
    output logic             irq
);
    logic [ISR_W-1:0] status_q;
    logic [ISR_W-1:0] wipe;

    always_comb begin
        wipe   = clr ? clr_bits : '0;
        status = status_q;
        irq    = |(status_q & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~wipe) | set_bits;
        end
    end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int unsigned PAGE_W    = 8,
    parameter int unsigned OFS_W     = 8,
    parameter int unsigned MIN_FRAME = 60,
    parameter int unsigned BC_LEN    = 6,
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned MISS_W    = 8,
    parameter int unsigned ISR_W     = 8,
    localparam int unsigned ADDR_W   = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_reset,
    input  logic [PAGE_W-1:0] ring_first,
    input  logic [PAGE_W-1:0] ring_last,
    input  logic [PAGE_W-1:0] guard_page,
    input  logic              accept_bcast,
    input  logic              cur_load,
    input  logic [PAGE_W-1:0] cur_load_page,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [ISR_W-1:0]  int_mask,
    input  logic              int_clr,
    input  logic [ISR_W-1:0]  int_clr_bits,
    output logic [ISR_W-1:0]  int_status,
    output logic              irq,
    output logic [PAGE_W-1:0] cur_page,
    output logic [7:0]        rx_status,
    output logic [MISS_W-1:0] missed_count
);
    localparam int unsigned HIDX_W = $clog2(RXR_HDR_LEN);
    localparam logic [HIDX_W-1:0] HIDX_LAST = HIDX_W'(RXR_HDR_LEN - 1);
    localparam logic [LEN_W-1:0]  MIN_L     = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0]  HDR_L     = LEN_W'(RXR_HDR_LEN);

    rxr_state_e st_q;
    rxr_state_e st_d;

    logic [PAGE_W-1:0] start_sel;
    logic [PAGE_W-1:0] start_pg_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  len_inc;
    logic [LEN_W-1:0]  len_desc;
    logic              bc_q;
    logic [HIDX_W-1:0] hidx_q;
    logic [PAGE_W-1:0] cur_q;
    logic [7:0]        rsr_q;
    logic [MISS_W-1:0] miss_q;
    logic [7:0]        stat_done;
    logic [7:0]        hdr_byte;

    logic              ptr_load;
    logic              ptr_step;
    logic [ADDR_W-1:0] ptr_addr;
    logic              ptr_guard_hit;
    logic [PAGE_W-1:0] ptr_next;

    logic              flt_clear;
    logic              flt_take;
    logic              flt_decide;
    logic              flt_keep;
    logic              flt_bcast;

    logic              ev_done;
    logic              ev_ovf;
    logic [ISR_W-1:0]  isr_set;

    rxr_ptr_unit #(
        .PAGE_W (PAGE_W),
        .OFS_W  (OFS_W),
        .SKIP_AT(RXR_HDR_LEN)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_page (start_sel),
        .step      (ptr_step),
        .ring_first(ring_first),
        .ring_last (ring_last),
        .guard_page(guard_page),
        .addr      (ptr_addr),
        .guard_hit (ptr_guard_hit),
        .next_page (ptr_next)
    );

    rxr_kind_filter #(
        .BC_LEN(BC_LEN)
    ) u_flt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (flt_clear),
        .take        (flt_take),
        .byte_in     (in_data),
        .last_in     (in_last),
        .accept_bcast(accept_bcast),
        .decide      (flt_decide),
        .keep        (flt_keep),
        .bcast       (flt_bcast)
    );

    rxr_int_unit #(
        .ISR_W(ISR_W)
    ) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_bits(isr_set),
        .clr     (int_clr),
        .clr_bits(int_clr_bits),
        .mask    (int_mask),
        .status  (int_status),
        .irq     (irq)
    );

    // Datapath helpers
    always_comb begin
        start_sel = (cur_q == ring_last) ? ring_first : cur_q;
        len_inc   = len_q + 1'b1;
        len_desc  = len_q + HDR_L;
        stat_done = STAT_OK | (bc_q ? STAT_BCAST : 8'h00);
        unique case (hidx_q)
            2'd0:    hdr_byte = stat_done;
            2'd1:    hdr_byte = 8'(ptr_next);
            2'd2:    hdr_byte = len_desc[7:0];
            default: hdr_byte = len_desc[15:8];
        endcase
        isr_set = '0;
        isr_set[ISR_DONE_BIT] = ev_done;
        isr_set[ISR_OVF_BIT]  = ev_ovf;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d      = st_q;
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_addr;
        mem_wdata = in_data;
        ptr_load  = 1'b0;
        ptr_step  = 1'b0;
        flt_clear = 1'b0;
        flt_take  = 1'b0;
        ev_done   = 1'b0;
        ev_ovf    = 1'b0;
        unique case (st_q)
            RX_IDLE: begin
                if (in_valid) begin
                    if (dev_reset) begin
                        st_d = RX_SKIP;
                    end else begin
                        st_d      = RX_TAKE;
                        ptr_load  = 1'b1;
                        flt_clear = 1'b1;
                    end
                end
            end
            RX_TAKE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mem_we   = 1'b1;
                    ptr_step = 1'b1;
                    flt_take = 1'b1;
                    if (flt_decide && !flt_keep) begin
                        st_d = in_last ? RX_IDLE : RX_SKIP;
                    end else if (ptr_guard_hit) begin
                        ev_ovf = 1'b1;
                        st_d   = in_last ? RX_IDLE : RX_SKIP;
                    end else if (in_last) begin
                        st_d = (len_inc < MIN_L) ? RX_FILL : RX_HEAD;
                    end
                end
            end
            RX_SKIP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    st_d = RX_IDLE;
                end
            end
            RX_FILL: begin
                mem_we    = 1'b1;
                mem_wdata = 8'h00;
                ptr_step  = 1'b1;
                if (len_inc >= MIN_L) begin
                    st_d = RX_HEAD;
                end
            end
            RX_HEAD: begin
                mem_we    = 1'b1;
                mem_addr  = {start_pg_q, OFS_W'(hidx_q)};
                mem_wdata = hdr_byte;
                if (hidx_q == HIDX_LAST) begin
                    ev_done = 1'b1;
                    st_d    = RX_IDLE;
                end
            end
            default: st_d = RX_IDLE;
        endcase
    end

    // Frame bookkeeping and committed registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pg_q <= '0;
            len_q      <= '0;
            bc_q       <= 1'b0;
            hidx_q     <= '0;
            cur_q      <= '0;
            rsr_q      <= '0;
            miss_q     <= '0;
        end else begin
            if (ptr_load) begin
                start_pg_q <= start_sel;
                len_q      <= '0;
                bc_q       <= 1'b0;
                hidx_q     <= '0;
            end
            if (flt_take || (st_q == RX_FILL)) begin
                len_q <= len_inc;
            end
            if (flt_decide && flt_keep && flt_bcast) begin
                bc_q <= 1'b1;
            end
            if (st_q == RX_HEAD) begin
                hidx_q <= hidx_q + 1'b1;
            end
            if (ev_done) begin
                cur_q <= ptr_next;
                rsr_q <= stat_done;
            end else if (cur_load) begin
                cur_q <= cur_load_page;
            end
            if (ev_ovf) begin
                rsr_q  <= STAT_OVF;
                miss_q <= miss_q + 1'b1;
            end
        end
    end

    assign cur_page     = cur_q;
    assign rx_status    = rsr_q;
    assign missed_count = miss_q;

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
    import rxr_pkg::*;
#(
    parameter int unsigned PAGE_W = 8,
    parameter int unsigned OFS_W  = 8,
    parameter int unsigned MISS_W = 8,
    parameter int unsigned ISR_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input rxr_state_e                st,
    input logic                      mem_we,
    input logic [PAGE_W+OFS_W-1:0]   mem_addr,
    input logic [PAGE_W-1:0]         ring_first,
    input logic [PAGE_W-1:0]         ring_last,
    input logic [PAGE_W-1:0]         cur_page,
    input logic                      cur_load,
    input logic                      int_clr,
    input logic [ISR_W-1:0]          int_clr_bits,
    input logic [ISR_W-1:0]          int_status,
    input logic                      ev_done,
    input logic                      ev_ovf,
    input logic [MISS_W-1:0]         missed_count
);
    logic [PAGE_W-1:0] wr_page;
    logic [OFS_W-1:0]  wr_ofs;
    assign wr_page = mem_addr[PAGE_W+OFS_W-1:OFS_W];
    assign wr_ofs  = mem_addr[OFS_W-1:0];

    assert_ring_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((wr_page >= ring_first) && (wr_page < ring_last)));

    assert_hdr_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_HEAD) |-> (mem_we && (wr_ofs < OFS_W'(RXR_HDR_LEN))));

    assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_SKIP) |-> !mem_we);

    assert_missed_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(missed_count) |-> (missed_count == MISS_W'($past(missed_count) + 1'b1)));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !ev_done && !ev_ovf) |=> ((int_status & $past(int_clr_bits)) == '0));

    assert_cur_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_page) && !$past(cur_load)) |-> ((cur_page >= ring_first) && (cur_page < ring_last)));

endmodule

bind rx_ring_writer rxr_checker #(
    .PAGE_W(PAGE_W),
    .OFS_W (OFS_W),
    .MISS_W(MISS_W),
    .ISR_W (ISR_W)
) u_rxr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st_q),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .ring_first  (ring_first),
    .ring_last   (ring_last),
    .cur_page    (cur_page),
    .cur_load    (cur_load),
    .int_clr     (int_clr),
    .int_clr_bits(int_clr_bits),
    .int_status  (int_status),
    .ev_done     (ev_done),
    .ev_ovf      (ev_ovf),
    .missed_count(missed_count)
);

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
    localparam int PW    = 4;
    localparam int AW    = PW + 8;
    localparam int MSZ   = 1 << AW;
    localparam int FIRST = 2;
    localparam int LAST  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dev_reset = 1'b0;
    logic [PW-1:0] ring_first = PW'(FIRST);
    logic [PW-1:0] ring_last  = PW'(LAST);
    logic [PW-1:0] guard_page = '0;
    logic          accept_bcast = 1'b1;
    logic          cur_load = 1'b0;
    logic [PW-1:0] cur_load_page = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    int_mask = 8'h00;
    logic          int_clr = 1'b0;
    logic [7:0]    int_clr_bits = '0;
    logic [7:0]    int_status;
    logic          irq;
    logic [PW-1:0] cur_page;
    logic [7:0]    rx_status;
    logic [7:0]    missed_count;

    always #5 clk = ~clk;

    rx_ring_writer #(.PAGE_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset),
        .ring_first(ring_first), .ring_last(ring_last), .guard_page(guard_page),
        .accept_bcast(accept_bcast), .cur_load(cur_load), .cur_load_page(cur_load_page),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .int_mask(int_mask), .int_clr(int_clr), .int_clr_bits(int_clr_bits),
        .int_status(int_status), .irq(irq), .cur_page(cur_page),
        .rx_status(rx_status), .missed_count(missed_count)
    );

    logic [7:0] bmem [MSZ];
    logic [7:0] emem [MSZ];
    logic [7:0] frm  [1024];
    int exp_cur, exp_rsr, exp_missed, exp_isr;
    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always_ff @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_frame(input int n);
        int off, pg, sp, len;
        bit mc, bc;
        int st;
        if (dev_reset) return;
        sp  = (exp_cur == LAST) ? FIRST : exp_cur;
        off = sp * 256 + 4;
        mc  = frm[0][0];
        bc  = (n >= 6);
        for (int i = 0; i < 6 && i < n; i++) if (frm[i] != 8'hFF) bc = 1'b0;
        if (mc && !(bc && accept_bcast)) begin
            for (int i = 0; i < 6 && i < n; i++) emem[off + i] = frm[i];
            return;
        end
        st = mc ? 8'h20 : 8'h00;
        for (int i = 0; i < n; i++) begin
            emem[off % MSZ] = frm[i];
            off++;
            if (off % 256 == 0) begin
                pg = (off / 256) % (1 << PW);
                if (pg == LAST) pg = FIRST;
                off = pg * 256;
                if (pg == int'(guard_page)) begin
                    exp_rsr = 8'h10;
                    exp_isr |= 8'h10;
                    exp_missed = (exp_missed + 1) & 8'hFF;
                    return;
                end
            end
        end
        len = n;
        while (len < 60) begin
            emem[off] = 8'h00;
            off++;
            len++;
        end
        pg = (off / 256) + ((off % 256) != 0 ? 1 : 0);
        if (pg == LAST) pg = FIRST;
        exp_cur = pg;
        st |= 1;
        exp_rsr = st;
        exp_isr |= 8'h01;
        emem[sp * 256 + 0] = 8'(st);
        emem[sp * 256 + 1] = 8'(pg);
        emem[sp * 256 + 2] = 8'((len + 4) & 255);
        emem[sp * 256 + 3] = 8'((len + 4) >> 8);
    endtask

    task automatic send_frame(input int n);
        bit ok;
        model_frame(n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = frm[i];
            in_last  = (i == n - 1);
            do begin
                #1 ok = in_ready;
                @(posedge clk);
                if (!ok) @(negedge clk);
            end while (!ok);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (75) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic verify(input string req);
        int bad = 0;
        int first_bad = -1;
        chk(int'(cur_page) == exp_cur, {req, " cur_page"}, int'(cur_page), exp_cur);
        chk(int'(rx_status) == exp_rsr, {req, " rx_status"}, int'(rx_status), exp_rsr);
        chk(int'(missed_count) == exp_missed, {req, " missed_count"}, int'(missed_count), exp_missed);
        chk(int'(int_status) == exp_isr, {req, " int_status"}, int'(int_status), exp_isr);
        chk(irq == |(8'(exp_isr) & int_mask), {req, " irq"}, int'(irq), int'(|(8'(exp_isr) & int_mask)));
        for (int a = 0; a < MSZ; a++) if (bmem[a] !== emem[a]) begin
            bad++;
            if (first_bad < 0) first_bad = a;
        end
        chk(bad == 0, {req, " memory image (actual=mismatches, expected=0)"}, bad, 0);
    endtask

    task automatic load_cur(input int p);
        @(negedge clk);
        cur_load = 1'b1;
        cur_load_page = PW'(p);
        @(negedge clk);
        cur_load = 1'b0;
        exp_cur = p;
    endtask

    task automatic clear_int(input logic [7:0] bits);
        @(negedge clk);
        int_clr = 1'b1;
        int_clr_bits = bits;
        @(negedge clk);
        int_clr = 1'b0;
        exp_isr &= ~int'(bits);
    endtask

    task automatic guard_behind();
        int c;
        c = (exp_cur == LAST) ? FIRST : exp_cur;
        guard_page = PW'((c == FIRST) ? LAST - 1 : c - 1);
    endtask

    // kind: 0 unicast, 1 broadcast, 2 other multicast
    task automatic make_frame(input int kind, input int n);
        for (int i = 0; i < n; i++) frm[i] = 8'($urandom);
        if (kind == 0) frm[0][0] = 1'b0;
        else if (kind == 1) for (int i = 0; i < 6 && i < n; i++) frm[i] = 8'hFF;
        else begin
            frm[0] = frm[0] | 8'h01;
            if (n > 1) frm[1] = 8'h00;
        end
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int a = 0; a < MSZ; a++) begin
            bmem[a] = 8'h00;
            emem[a] = 8'h00;
        end
        exp_cur = 0; exp_rsr = 0; exp_missed = 0; exp_isr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cur_page == '0 && rx_status == 8'h00, "R11 reset pointers", int'(cur_page), 0);
        chk(missed_count == 8'h00 && int_status == 8'h00 && !irq, "R11 reset status", int'(int_status), 0);
        load_cur(FIRST);
        chk(int'(cur_page) == FIRST, "R11 cur_load", int'(cur_page), FIRST);

        // R6: short unicast padded to 60
        int_mask = 8'h11;
        guard_behind(); make_frame(0, 20); send_frame(20); verify("R6 short pad");
        // R6: exactly 60 bytes
        guard_behind(); make_frame(0, 60); send_frame(60); verify("R6 exact 60");
        // R3: broadcast kept
        accept_bcast = 1'b1;
        guard_behind(); make_frame(1, 100); send_frame(100); verify("R3 broadcast 0x21");
        // R2: broadcast rejected when disabled
        accept_bcast = 1'b0;
        guard_behind(); make_frame(1, 100); send_frame(100); verify("R2 broadcast off");
        accept_bcast = 1'b1;
        // R2: other multicast dropped, long and short
        guard_behind(); make_frame(2, 80); send_frame(80); verify("R2 multicast drop");
        guard_behind(); make_frame(2, 3); send_frame(3); verify("R2 short multicast");
        // R7: payload ends exactly at a page end
        guard_behind(); make_frame(0, 252); send_frame(252); verify("R7 exact page end");
        // R4: crossing the stop page wraps
        load_cur(LAST - 1);
        guard_behind(); make_frame(0, 600); send_frame(600); verify("R4 stop wrap");
        // R1: current page equal to stop starts at first
        load_cur(LAST);
        guard_behind(); make_frame(0, 70); send_frame(70); verify("R1 start at first");
        // R5: overflow into guard page
        guard_page = PW'(exp_cur + 1);
        make_frame(0, 400); send_frame(400); verify("R5 overflow");
        // R9: ignored during device reset
        dev_reset = 1'b1;
        guard_behind(); make_frame(0, 90); send_frame(90); verify("R9 dev reset");
        dev_reset = 1'b0;
        // R10: mask and write-one-to-clear
        int_mask = 8'h01;
        @(negedge clk);
        chk(irq == 1'b1, "R10 irq masked on", int'(irq), 1);
        clear_int(8'h01);
        chk(int'(int_status) == exp_isr && !irq, "R10 clear done bit", int'(int_status), exp_isr);
        clear_int(8'hFF);
        chk(int_status == 8'h00, "R10 clear all", int'(int_status), 0);
        int_mask = 8'h11;

        // Random phase (R1 R2 R3 R4 R5 R6 R7 R8)
        for (int k = 0; k < 60; k++) begin
            int kind, n;
            kind = int'($urandom_range(0, 3));
            if (kind == 3) kind = 0;
            n = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 59)) : int'($urandom_range(60, 700));
            accept_bcast = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) begin
                int c;
                c = (exp_cur == LAST) ? FIRST : exp_cur;
                guard_page = PW'((c + 1 == LAST) ? FIRST : c + 1);
            end else guard_behind();
            make_frame(kind, n);
            send_frame(n);
            verify("R8 random frame");
            if ($urandom_range(0, 3) == 0) clear_int(8'($urandom));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule